// File: doc/BRIEF.md
# Low-Power Standby Wake-Up Sequencer

This block walks a chip into and out of its standby modes through a fixed handshake with its neighbours. When a standby request is accepted, it closes the system bus and puts every memory controller into self-refresh. It waits for each controller to confirm, moves the clock onto the crystal oscillator, and then powers down domains or holds the CPU in reset, as the chosen mode needs. While in standby it waits for a wake-up event. It then runs the same steps in reverse order and gives one `done` pulse when normal operation resumes.

Three standby modes are supported. In the light mode, only the clocks stop and the CPU keeps its state. In the deep mode, the CPU domain loses power and the CPU is held in reset. In the deepest mode, every switchable domain is powered off, so only the always-on logic that watches for the wake-up event stays alive. The regulators, the PLL and the memory controllers are not part of this block. They appear only as request and acknowledge lines.

A programmable limit sets how long any handshake wait may take. If a wait exceeds it, a sticky error flag is raised.

Top module: `lpWakeSeq`

## Requirements
- R1: After reset, every output is low, `curMode` reads 2'b00 (normal) and the clock select points at the oscillator.
- R2: On entry, `busDownReq` rises before any `srReq` line rises, and `srReq` is never high while `busDownReq` is low. `clkSelPll` falls to the oscillator only after every `memAck` line is high.
- R3: Once entry completes, the mode decides the outputs. Mode 2'b01 (light) gates no domain and leaves `cpuRst` low. Mode 2'b10 (deep) powers off domain bit 0 (the CPU) and raises `cpuRst`. Mode 2'b11 (deepest) powers off every domain. No domain is powered off while `clkSelPll` is high.
- R4: A request for mode 2'b11 while any `domainOn` bit is low is refused. `rejected` pulses in the cycle after the request, and the block stays in normal mode with `busDownReq` low.
- R5: While in normal mode, a `wakeEvent` has no effect. A request with `modeSel` 2'b00 is also ignored.
- R6: On wake-up, all power-off lines drop first. The clock step waits until every `domainOn` bit is high.
- R7: On exit with `pllEnable` high, `clkSelPll` rises only after `pllLock` is seen high. With `pllEnable` low, the clock stays on the oscillator.
- R8: Once the clock step is done, every `srReq` line falls. `busDownReq` falls only after every `memAck` line is low.
- R9: `cpuRst` is only ever high in the deep mode. It is released as the last step, after `busDownReq` has fallen.
- R10: `busy` rises in the cycle after the wake-up event and stays high until the cycle in which `done` pulses, when it falls. `done` is high for exactly one cycle.
- R11: `timeoutErr` sets once a single handshake wait has lasted `timeoutLimit` cycles (a limit of 0 disables this). It holds until the next accepted standby request.
- R12: `curMode` shows the standby mode (encoded 2'b00 normal, 2'b01 light, 2'b10 deep, 2'b11 deepest) from the end of entry until `done`. It returns to 2'b00 at `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enterReq | input | 1 | Request to enter the standby mode given on `modeSel` |
| modeSel | input | 2 | Requested mode: 00 normal, 01 light, 10 deep, 11 deepest |
| wakeEvent | input | 1 | Wake-up event from the always-on domain |
| pllEnable | input | 1 | PLL is to be used as the clock after wake-up |
| pllLock | input | 1 | PLL reports lock |
| memAck | input | NUM_MEM | Per-controller self-refresh acknowledge (follows `srReq`) |
| domainOn | input | NUM_DOM | Per-domain power-good status; bit 0 is the CPU domain |
| timeoutLimit | input | CNT_W | Cycle limit for one handshake wait, 0 disables |
| clkSelPll | output | 1 | Clock source select: 1 PLL, 0 oscillator |
| srReq | output | NUM_MEM | Self-refresh requests to the memory controllers |
| busDownReq | output | 1 | Request to bring the system bus down |
| cpuRst | output | 1 | CPU core reset, active high |
| domPwrOff | output | NUM_DOM | Per-domain power-off requests |
| curMode | output | 2 | Current standby mode |
| busy | output | 1 | Exit sequence in progress |
| done | output | 1 | One-cycle pulse on return to normal mode |
| rejected | output | 1 | One-cycle pulse on a refused deepest-mode request |
| timeoutErr | output | 1 | Sticky handshake timeout flag |

## Verification
The assertions assume the neighbours follow a four-phase handshake. Each `memAck` copies its `srReq` after some delay, and each `domainOn` copies the inverse of its `domPwrOff` after some delay. `pllLock` only means something while `pllEnable` is high, and `pllEnable` is held constant across a whole standby cycle.

The bench keeps within these limits. Its memory, power and PLL models react at the falling edge with random delays drawn from a fixed seed. It changes `pllEnable` only while the block is in normal mode. It breaks the handshake on purpose only in two places: it holds the acknowledges back for the timeout case, and it forces a domain off for the refused-request case.

// File: rtl/lpWakeSeqPkg.sv
package lpWakeSeqPkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_STOP   = 2'b01,
    MODE_DEEP   = 2'b10,
    MODE_SLEEP  = 2'b11
  } mode_e;

  typedef enum logic [3:0] {
    S_NORMAL,
    S_EN_SR,
    S_EN_ACK,
    S_EN_GATE,
    S_LOW,
    S_X_PWR,
    S_X_CLK,
    S_X_SR,
    S_X_ACK,
    S_X_CPU
  } state_e;

  // Strobes from the sequencing FSM to the datapath
  typedef struct packed {
    logic setBus;
    logic clrBus;
    logic setSr;
    logic clrSr;
    logic clkToOsc;
    logic clkToPll;
    logic gateDom;
    logic ungateDom;
    logic clrCpuRst;
    logic cntClr;
    logic cntEn;
    logic errClr;
    logic donePulse;
    logic rejectPulse;
  } seqStrobe_t;

endpackage

// File: rtl/lpWakeSeqCtrl.sv
module lpWakeSeqCtrl
  import lpWakeSeqPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enterReq,
  input  logic [1:0] modeSel,
  input  logic       wakeEvent,
  input  logic       pllEnable,
  input  logic       pllLock,
  input  logic       ackAll,
  input  logic       ackNone,
  input  logic       domAllOn,
  output seqStrobe_t strobe,
  output logic [1:0] gateMode,
  output logic [1:0] curMode,
  output logic       busy
);

  state_e stateQ, stateD;
  mode_e  pendQ, pendD;
  mode_e  modeQ, modeD;

  always_comb begin
    stateD = stateQ;
    pendD  = pendQ;
    modeD  = modeQ;
    strobe = '0;
    unique case (stateQ)
      S_NORMAL: begin
        if (enterReq && modeSel != MODE_NORMAL) begin
          if (modeSel == MODE_SLEEP && !domAllOn) begin
            strobe.rejectPulse = 1'b1;
          end else begin
            pendD         = mode_e'(modeSel);
            strobe.errClr = 1'b1;
            strobe.setBus = 1'b1;
            stateD        = S_EN_SR;
          end
        end
      end
      S_EN_SR: begin
        strobe.setSr  = 1'b1;
        strobe.cntClr = 1'b1;
        stateD        = S_EN_ACK;
      end
      S_EN_ACK: begin
        if (ackAll) begin
          strobe.clkToOsc = 1'b1;
          stateD          = S_EN_GATE;
        end else begin
          strobe.cntEn = 1'b1;
        end
      end
      S_EN_GATE: begin
        strobe.gateDom = 1'b1;
        modeD          = pendQ;
        stateD         = S_LOW;
      end
      S_LOW: begin
        if (wakeEvent) begin
          strobe.ungateDom = 1'b1;
          strobe.cntClr    = 1'b1;
          stateD           = S_X_PWR;
        end
      end
      S_X_PWR: begin
        if (domAllOn) begin
          strobe.cntClr = 1'b1;
          stateD        = S_X_CLK;
        end else begin
          strobe.cntEn = 1'b1;
        end
      end
      S_X_CLK: begin
        if (!pllEnable) begin
          stateD = S_X_SR;
        end else if (pllLock) begin
          strobe.clkToPll = 1'b1;
          stateD          = S_X_SR;
        end else begin
          strobe.cntEn = 1'b1;
        end
      end
      S_X_SR: begin
        strobe.clrSr  = 1'b1;
        strobe.cntClr = 1'b1;
        stateD        = S_X_ACK;
      end
      S_X_ACK: begin
        if (ackNone) begin
          strobe.clrBus = 1'b1;
          stateD        = S_X_CPU;
        end else begin
          strobe.cntEn = 1'b1;
        end
      end
      S_X_CPU: begin
        strobe.clrCpuRst = 1'b1;
        strobe.donePulse = 1'b1;
        modeD            = MODE_NORMAL;
        stateD           = S_NORMAL;
      end
      default: stateD = S_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_NORMAL;
      pendQ  <= MODE_NORMAL;
      modeQ  <= MODE_NORMAL;
    end else begin
      stateQ <= stateD;
      pendQ  <= pendD;
      modeQ  <= modeD;
    end
  end

  assign gateMode = pendQ;
  assign curMode  = modeQ;
  assign busy     = (stateQ == S_X_PWR) || (stateQ == S_X_CLK) ||
                    (stateQ == S_X_SR)  || (stateQ == S_X_ACK) ||
                    (stateQ == S_X_CPU);

  // A refused deepest-mode request leaves the FSM in normal mode
  assert_reject_stays_R4: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_NORMAL && enterReq && modeSel == MODE_SLEEP && !domAllOn)
      |=> (stateQ == S_NORMAL));

  // Wake-up in normal mode starts nothing
  assert_wake_ignored_R5: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_NORMAL && wakeEvent && !enterReq) |=> !busy);

  // Standby mode is only reported while not in the normal state
  assert_mode_visible_R12: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_NORMAL) |-> (modeQ == MODE_NORMAL));

endmodule

// File: rtl/lpWakeSeqPath.sv
module lpWakeSeqPath
  import lpWakeSeqPkg::*;
#(
  parameter int NUM_MEM = 2,
  parameter int NUM_DOM = 4,
  parameter int CPU_DOM = 0,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [1:0]         gateMode,
  input  logic [NUM_MEM-1:0] memAck,
  input  logic [NUM_DOM-1:0] domainOn,
  input  logic [CNT_W-1:0]   timeoutLimit,
  output logic               clkSelPll,
  output logic [NUM_MEM-1:0] srReq,
  output logic               busDownReq,
  output logic               cpuRst,
  output logic [NUM_DOM-1:0] domPwrOff,
  output logic               done,
  output logic               rejected,
  output logic               timeoutErr,
  output logic               ackAll,
  output logic               ackNone,
  output logic               domAllOn
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;

  assign ackAll   = &memAck;
  assign ackNone  = ~|memAck;
  assign domAllOn = &domainOn;
  assign cntNext  = cntQ + CNT_W'(1);

  // Per-channel self-refresh request registers
  for (genvar m = 0; m < NUM_MEM; m++) begin : g_sr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             srReq[m] <= 1'b0;
      else if (strobe.setSr) srReq[m] <= 1'b1;
      else if (strobe.clrSr) srReq[m] <= 1'b0;
    end
  end

  // Per-domain power-off registers; the CPU domain also goes off in deep mode
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    logic offInMode;
    if (d == CPU_DOM) begin : g_cpu
      assign offInMode = (gateMode == MODE_DEEP) || (gateMode == MODE_SLEEP);
    end else begin : g_other
      assign offInMode = (gateMode == MODE_SLEEP);
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                               domPwrOff[d] <= 1'b0;
      else if (strobe.ungateDom)               domPwrOff[d] <= 1'b0;
      else if (strobe.gateDom && offInMode)    domPwrOff[d] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkSelPll  <= 1'b0;
      busDownReq <= 1'b0;
      cpuRst     <= 1'b0;
      done       <= 1'b0;
      rejected   <= 1'b0;
    end else begin
      if (strobe.clkToOsc)      clkSelPll <= 1'b0;
      else if (strobe.clkToPll) clkSelPll <= 1'b1;
      if (strobe.setBus)        busDownReq <= 1'b1;
      else if (strobe.clrBus)   busDownReq <= 1'b0;
      if (strobe.gateDom && gateMode == MODE_DEEP) cpuRst <= 1'b1;
      else if (strobe.clrCpuRst)                   cpuRst <= 1'b0;
      done     <= strobe.donePulse;
      rejected <= strobe.rejectPulse;
    end
  end

  // Handshake wait counter and sticky timeout flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ       <= '0;
      timeoutErr <= 1'b0;
    end else begin
      if (strobe.cntClr)                        cntQ <= '0;
      else if (strobe.cntEn && cntQ != CNT_MAX) cntQ <= cntNext;
      if (strobe.errClr)
        timeoutErr <= 1'b0;
      else if (strobe.cntEn && timeoutLimit != '0 && cntNext == timeoutLimit)
        timeoutErr <= 1'b1;
    end
  end

  assert_sr_under_bus_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|srReq) |-> busDownReq);

  assert_gate_on_osc_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|domPwrOff) |-> !clkSelPll);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_timeout_from_wait_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> $past(strobe.cntEn));

  assert_bus_after_ack_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busDownReq) |-> $past(ackNone));

endmodule

// File: rtl/lpWakeSeq.sv
module lpWakeSeq
  import lpWakeSeqPkg::*;
#(
  parameter int NUM_MEM = 2,
  parameter int NUM_DOM = 4,
  parameter int CPU_DOM = 0,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enterReq,
  input  logic [1:0]         modeSel,
  input  logic               wakeEvent,
  input  logic               pllEnable,
  input  logic               pllLock,
  input  logic [NUM_MEM-1:0] memAck,
  input  logic [NUM_DOM-1:0] domainOn,
  input  logic [CNT_W-1:0]   timeoutLimit,
  output logic               clkSelPll,
  output logic [NUM_MEM-1:0] srReq,
  output logic               busDownReq,
  output logic               cpuRst,
  output logic [NUM_DOM-1:0] domPwrOff,
  output logic [1:0]         curMode,
  output logic               busy,
  output logic               done,
  output logic               rejected,
  output logic               timeoutErr
);

  seqStrobe_t strobe;
  logic [1:0] gateMode;
  logic       ackAll, ackNone, domAllOn;

  lpWakeSeqCtrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enterReq  (enterReq),
    .modeSel   (modeSel),
    .wakeEvent (wakeEvent),
    .pllEnable (pllEnable),
    .pllLock   (pllLock),
    .ackAll    (ackAll),
    .ackNone   (ackNone),
    .domAllOn  (domAllOn),
    .strobe    (strobe),
    .gateMode  (gateMode),
    .curMode   (curMode),
    .busy      (busy)
  );

  lpWakeSeqPath #(
    .NUM_MEM (NUM_MEM),
    .NUM_DOM (NUM_DOM),
    .CPU_DOM (CPU_DOM),
    .CNT_W   (CNT_W)
  ) i_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .gateMode     (gateMode),
    .memAck       (memAck),
    .domainOn     (domainOn),
    .timeoutLimit (timeoutLimit),
    .clkSelPll    (clkSelPll),
    .srReq        (srReq),
    .busDownReq   (busDownReq),
    .cpuRst       (cpuRst),
    .domPwrOff    (domPwrOff),
    .done         (done),
    .rejected     (rejected),
    .timeoutErr   (timeoutErr),
    .ackAll       (ackAll),
    .ackNone      (ackNone),
    .domAllOn     (domAllOn)
  );

  assert_pll_after_lock_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSelPll) |-> $past(pllEnable && pllLock));

  assert_cpu_rst_deep_R9: assert property (@(posedge clk) disable iff (!rstN)
    cpuRst |-> (curMode == MODE_DEEP));

  assert_pwr_before_clk_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkSelPll) |-> (domPwrOff == '0));

endmodule

// File: tb/test_lpWakeSeq.sv
module test_lpWakeSeq;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_MEM = 2;
  localparam int NUM_DOM = 4;
  localparam int CNT_W   = 16;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               enterReq = 1'b0;
  logic [1:0]         modeSel = 2'b00;
  logic               wakeEvent = 1'b0;
  logic               pllEnable = 1'b0;
  logic               pllLock = 1'b0;
  logic [NUM_MEM-1:0] memAck = '0;
  logic [NUM_DOM-1:0] domainOn = '1;
  logic [CNT_W-1:0]   timeoutLimit = 16'd1000;
  logic               clkSelPll, busDownReq, cpuRst, busy, done, rejected, timeoutErr;
  logic [NUM_MEM-1:0] srReq;
  logic [NUM_DOM-1:0] domPwrOff;
  logic [1:0]         curMode;

  int checks = 0;
  int failures = 0;
  bit ackHold = 1'b0;
  logic [NUM_DOM-1:0] forceOff = '0;
  bit finished = 1'b0;

  lpWakeSeq #(.NUM_MEM(NUM_MEM), .NUM_DOM(NUM_DOM), .CPU_DOM(0), .CNT_W(CNT_W)) i_lpWakeSeq (
    .clk(clk), .rstN(rstN), .enterReq(enterReq), .modeSel(modeSel),
    .wakeEvent(wakeEvent), .pllEnable(pllEnable), .pllLock(pllLock),
    .memAck(memAck), .domainOn(domainOn), .timeoutLimit(timeoutLimit),
    .clkSelPll(clkSelPll), .srReq(srReq), .busDownReq(busDownReq),
    .cpuRst(cpuRst), .domPwrOff(domPwrOff), .curMode(curMode), .busy(busy),
    .done(done), .rejected(rejected), .timeoutErr(timeoutErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [NUM_DOM-1:0] expOff(input logic [1:0] m);
    if (m == 2'b11) return '1;
    if (m == 2'b10) return NUM_DOM'(1);
    return '0;
  endfunction

  function automatic logic expRst(input logic [1:0] m);
    return (m == 2'b10);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Neighbour models and ordering monitor, evaluated at the falling edge
  initial begin
    int ackDly[NUM_MEM];
    int domDly[NUM_DOM];
    int lockCnt = 0;
    int lockDelay = 3;
    logic pClk = 1'b0, pBus = 1'b0, pCpu = 1'b0, pBusy = 1'b0, pDone = 1'b0;
    logic [NUM_MEM-1:0] pSr = '0;
    logic [NUM_DOM-1:0] pOff = '0;
    foreach (ackDly[i]) ackDly[i] = 0;
    foreach (domDly[i]) domDly[i] = 0;
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (pSr == '0 && srReq != '0)
          check(busDownReq, "R2", "bus down before self-refresh", busDownReq, 1);
        if (pClk && !clkSelPll)
          check(&memAck, "R2", "acks before oscillator switch", memAck, '1);
        if (pOff == '0 && domPwrOff != '0)
          check(!clkSelPll, "R3", "gating on oscillator", clkSelPll, 0);
        if (!pClk && clkSelPll) begin
          check(pllEnable && pllLock, "R7", "lock before PLL select", pllLock, 1);
          check(&domainOn && domPwrOff == '0, "R6", "power back before clock", domainOn, '1);
        end
        if (pSr != '0 && srReq == '0)
          check(clkSelPll == pllEnable, "R8", "clock step before self-refresh release", clkSelPll, pllEnable);
        if (pBus && !busDownReq)
          check(memAck == '0 && srReq == '0, "R8", "acks low before bus release", memAck, 0);
        if (pCpu && !cpuRst)
          check(!busDownReq, "R9", "cpu reset released last", busDownReq, 0);
        if (!pCpu && cpuRst)
          check(curMode == 2'b10, "R9", "cpu reset only in deep mode", curMode, 2);
        if (done)
          check(pBusy && !busy && !pDone, "R10", "busy ends at single done", busy, 0);
      end
      pClk = clkSelPll; pBus = busDownReq; pCpu = cpuRst; pBusy = busy;
      pDone = done; pSr = srReq; pOff = domPwrOff;
      for (int i = 0; i < NUM_MEM; i++) begin
        if (!ackHold && memAck[i] != srReq[i]) begin
          if (ackDly[i] == 0) begin
            memAck[i] = srReq[i];
            ackDly[i] = int'($urandom % 4);
          end else ackDly[i]--;
        end
      end
      for (int i = 0; i < NUM_DOM; i++) begin
        if (forceOff[i]) domainOn[i] = 1'b0;
        else if (domainOn[i] == domPwrOff[i]) begin
          if (domDly[i] == 0) begin
            domainOn[i] = !domPwrOff[i];
            domDly[i] = int'($urandom % 5);
          end else domDly[i]--;
        end
      end
      if (busy && pllEnable) begin
        lockCnt++;
        pllLock = (lockCnt >= lockDelay);
      end else begin
        lockCnt = 0;
        lockDelay = int'($urandom % 7);
        pllLock = 1'b0;
      end
    end
  end

  task automatic pulseEnter(input logic [1:0] m);
    @(negedge clk);
    modeSel = m;
    enterReq = 1'b1;
    @(negedge clk);
    enterReq = 1'b0;
  endtask

  task automatic enterMode(input logic [1:0] m);
    int n = 0;
    pulseEnter(m);
    while (curMode != m && n < 400) begin
      @(negedge clk);
      n++;
    end
    check(curMode == m, "R12", "mode reported after entry", curMode, m);
    check(domPwrOff == expOff(m), "R3", "power-off pattern", domPwrOff, expOff(m));
    check(cpuRst == expRst(m), "R3", "cpu reset in standby", cpuRst, expRst(m));
    check(!clkSelPll && busDownReq && srReq == '1, "R2", "entry outputs", {clkSelPll, busDownReq}, 1);
  endtask

  task automatic wakeUp(input logic pllEn);
    int n = 0;
    bit busyOk = 1'b1;
    @(negedge clk);
    wakeEvent = 1'b1;
    @(negedge clk);
    wakeEvent = 1'b0;
    check(busy, "R10", "busy after wake", busy, 1);
    while (!done && n < 600) begin
      if (!busy) busyOk = 1'b0;
      @(negedge clk);
      n++;
    end
    check(done && busyOk, "R10", "busy held until done", done, 1);
    check(clkSelPll == pllEn, "R7", "clock source after exit", clkSelPll, pllEn);
    check(srReq == '0 && !busDownReq, "R8", "bus and self-refresh released", busDownReq, 0);
    check(!cpuRst && domPwrOff == '0, "R9", "cpu reset and power restored", cpuRst, 0);
    check(curMode == 2'b00, "R12", "mode back to normal", curMode, 0);
    @(negedge clk);
    check(!done, "R10", "done lasts one cycle", done, 0);
  endtask

  // Watchdog
  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check(!clkSelPll && !busDownReq && srReq == '0 && !cpuRst && domPwrOff == '0
          && !busy && !done && curMode == 2'b00, "R1", "reset state", curMode, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(!busDownReq && curMode == 2'b00, "R1", "idle after reset", busDownReq, 0);

    // R5: wake in normal mode and a mode-00 request do nothing
    @(negedge clk);
    wakeEvent = 1'b1;
    @(negedge clk);
    wakeEvent = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !busDownReq && clkSelPll == 1'b0, "R5", "wake ignored in normal", busy, 0);
    pulseEnter(2'b00);
    repeat (3) @(negedge clk);
    check(!busDownReq && srReq == '0, "R5", "normal-mode request ignored", busDownReq, 0);

    // R4: deepest mode refused while a domain is off
    forceOff = 4'b0100;
    repeat (3) @(negedge clk);
    pulseEnter(2'b11);
    check(rejected, "R4", "reject pulse", rejected, 1);
    @(negedge clk);
    check(!rejected && !busDownReq && curMode == 2'b00, "R4", "stays normal after reject", busDownReq, 0);
    forceOff = '0;
    repeat (8) @(negedge clk);

    // Directed cycles through each mode
    pllEnable = 1'b1;
    enterMode(2'b10); wakeUp(1'b1);
    pllEnable = 1'b0;
    enterMode(2'b11); wakeUp(1'b0);
    pllEnable = 1'b1;
    enterMode(2'b01); wakeUp(1'b1);

    // R11: acknowledges withheld beyond the limit
    timeoutLimit = 16'd12;
    ackHold = 1'b1;
    pulseEnter(2'b01);
    repeat (5) @(negedge clk);
    check(!timeoutErr, "R11", "no error before limit", timeoutErr, 0);
    repeat (20) @(negedge clk);
    check(timeoutErr, "R11", "error after limit", timeoutErr, 1);
    ackHold = 1'b0;
    timeoutLimit = 16'd1000;
    begin
      int n = 0;
      while (curMode != 2'b01 && n < 400) begin @(negedge clk); n++; end
    end
    wakeUp(1'b1);
    check(timeoutErr, "R11", "error sticky after exit", timeoutErr, 1);
    enterMode(2'b01);
    check(!timeoutErr, "R11", "error cleared by new request", timeoutErr, 0);
    wakeUp(1'b1);

    // Constrained random cycles
    for (int k = 0; k < 12; k++) begin
      logic [1:0] m;
      logic pe;
      m = 2'(1 + ($urandom % 3));
      pe = 1'($urandom % 2);
      @(negedge clk);
      pllEnable = pe;
      enterMode(m);
      repeat (2 + ($urandom % 9)) @(negedge clk);
      wakeUp(pe);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule